// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit applies one of four single-bit operations to a 64-bit source word: force one bit to 1, force one bit to 0, flip one bit, or read one bit out as a 0/1 value. The position of the bit comes from one of two places. It is either the low bits of a register-sourced operand or a short immediate field. Both forms give the same result for the same position.

Internally, a one-hot mask is built from the selected position. That single mask feeds the set, clear and flip paths. The read-out path shifts the source right and keeps only the lowest bit. An enable input tells the unit whether the bit-manipulation extension is active. When it is not, every issued operation is flagged illegal and produces a zero word.

Operands are captured on a valid strobe. The result, the illegal flag and an output valid appear from registers one clock later.

Top module: `bitop_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `result` and `illegal` are all 0.
- R2: The bit position is `reg_idx` taken modulo 64 (only bits 5:0 matter) when `idx_from_imm` is 0, and `imm_idx` when `idx_from_imm` is 1; bits 63:6 of `reg_idx` have no effect on the result.
- R3: With `op_sel` = 2'b00 (set), `result` equals `src` with the selected bit forced to 1 and all other bits unchanged.
- R4: With `op_sel` = 2'b01 (clear), `result` equals `src` with the selected bit forced to 0 and all other bits unchanged.
- R5: With `op_sel` = 2'b10 (invert), `result` equals `src` with the selected bit flipped and all other bits unchanged.
- R6: With `op_sel` = 2'b11 (extract), `result[0]` equals the selected bit of `src` and `result[63:1]` are 0.
- R7: When `ext_en` is 0 at issue, `illegal` is 1 and `result` is 0. When `ext_en` is 1, `illegal` is 0.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result`/`illegal` belong to that operation.
- R9: In a cycle following one with `in_valid` low, `result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_sel | input | 2 | 00 set, 01 clear, 10 invert, 11 extract |
| idx_from_imm | input | 1 | 1 selects `imm_idx`, 0 selects `reg_idx` |
| reg_idx | input | 64 | Register-sourced bit position (low 6 bits used) |
| imm_idx | input | 6 | Immediate bit position |
| src | input | 64 | Source word |
| ext_en | input | 1 | Extension enabled |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Operation result |
| illegal | output | 1 | Operation issued while extension disabled |

## Verification
A wrong mask would show up at `result` in the cycle after issue. It would appear as a word that differs from the source in zero bits or in more than one bit, or in the wrong position. A bad index selection would show the same pattern, but only when the two index sources disagree. For that reason the stimulus deliberately puts conflicting values in `reg_idx` and `imm_idx`, and fills the upper bits of `reg_idx`. Errors in the output register or valid path show one cycle after issue, as a missing strobe, a stale word or a result that changes during an idle cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_SET = 2'b00,
    BOP_CLR = 2'b01,
    BOP_INV = 2'b10,
    BOP_EXT = 2'b11
  } bop_e;
endpackage

// File: rtl/bitop_index_sel.sv
module bitop_index_sel #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              from_imm,
  input  logic [DATA_W-1:0] reg_idx,
  input  logic [IDX_W-1:0]  imm_idx,
  output logic [IDX_W-1:0]  idx
);
  logic [DATA_W-1:0] reg_mod;

  // position wraps at the word width
  always_comb begin
    reg_mod = reg_idx % DATA_W;
    idx     = from_imm ? imm_idx : reg_mod[IDX_W-1:0];
  end
endmodule

// File: rtl/bitop_mask_gen.sv
module bitop_mask_gen #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  // one decoder leg per bit position
  for (genvar g = 0; g < DATA_W; g++) begin : g_leg
    assign mask[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  bop_e              op,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] mask,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = src >> idx;
    unique case (op)
      BOP_SET: res = src | mask;
      BOP_CLR: res = src & ~mask;
      BOP_INV: res = src ^ mask;
      default: res = {{(DATA_W-1){1'b0}}, shifted[0]};
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic              idx_from_imm,
  input  logic [DATA_W-1:0] reg_idx,
  input  logic [IDX_W-1:0]  imm_idx,
  input  logic [DATA_W-1:0] src,
  input  logic              ext_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] alu_res;

  bitop_index_sel #(.DATA_W(DATA_W)) u_isel (
    .from_imm (idx_from_imm),
    .reg_idx  (reg_idx),
    .imm_idx  (imm_idx),
    .idx      (idx)
  );

  bitop_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .idx  (idx),
    .mask (mask)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (bop_e'(op_sel)),
    .src  (src),
    .mask (mask),
    .idx  (idx),
    .res  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= ext_en ? alu_res : '0;
        illegal <= ~ext_en;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic              ext_en,
  input logic [DATA_W-1:0] src,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  logic issue_ok;
  assign issue_ok = in_valid && ext_en;

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_disabled_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ext_en) |=> (illegal && result == '0));

  assert_enabled_legal_R7: assert property (@(posedge clk) disable iff (rst)
    issue_ok |=> !illegal);

  assert_set_only_adds_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && op_sel == 2'b00) |=>
      ((result & $past(src)) == $past(src) && $countones(result ^ $past(src)) <= 1));

  assert_clr_only_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && op_sel == 2'b01) |=>
      ((result & ~$past(src)) == '0 && $countones(result ^ $past(src)) <= 1));

  assert_inv_one_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && op_sel == 2'b10) |=> ($countones(result ^ $past(src)) == 1));

  assert_ext_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && op_sel == 2'b11) |=> (result[DATA_W-1:1] == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .ext_en    (ext_en),
  .src       (src),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        idx_from_imm = 1'b0;
  logic [63:0] reg_idx = '0;
  logic [5:0]  imm_idx = '0;
  logic [63:0] src = '0;
  logic        ext_en = 1'b1;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  logic [63:0] last_res = '0;

  logic [63:0] q_res[$];
  bit          q_ill[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .idx_from_imm(idx_from_imm), .reg_idx(reg_idx), .imm_idx(imm_idx),
    .src(src), .ext_en(ext_en), .out_valid(out_valid), .result(result),
    .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input bit imm,
      input logic [63:0] ri, input logic [5:0] ii, input logic [63:0] s,
      input bit en);
    int pos;
    logic [63:0] m;
    if (!en) return '0;
    pos = imm ? int'(ii) : int'(ri[5:0]);
    m = 64'd1 << pos;
    case (op)
      2'b00: return s | m;
      2'b01: return s & ~m;
      2'b10: return s ^ m;
      default: return {63'd0, s[pos]};
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input bit imm, input logic [63:0] ri,
      input logic [5:0] ii, input logic [63:0] s, input bit en, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; idx_from_imm = imm; reg_idx = ri;
    imm_idx = ii; src = s; ext_en = en;
    q_res.push_back(model(op, imm, ri, ii, s, en));
    q_ill.push_back(!en);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src = ~src; reg_idx = ~reg_idx;
    end
  endtask

  // monitor: pops one expected item per output strobe
  always @(negedge clk) begin
    if (started && !rst) begin
      if (out_valid) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R8 unexpected out_valid", {63'd0, out_valid}, 64'd0);
        end else begin
          logic [63:0] er;
          bit ei;
          string t;
          er = q_res.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
          check(result === er, t, result, er);
          check(illegal === ei, {t, " R7 illegal"}, {63'd0, illegal}, {63'd0, ei});
          last_res = er;
        end
      end else if (q_res.size() == 0) begin
        check(result === last_res, "R9 idle hold", result, last_res);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", q_res.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    check(result === 64'd0, "R1 result", result, 64'd0);
    check(illegal === 1'b0, "R1 illegal", {63'd0, illegal}, 64'd0);
    rst = 1'b0;
    started = 1'b1;

    issue(2'b00, 0, 64'd0, 6'd33, 64'd0, 1, "R3 set bit0 reg");
    issue(2'b00, 1, 64'd5, 6'd63, 64'h0123_4567_89AB_CDEF, 1, "R3 set bit63 imm");
    issue(2'b00, 0, 64'd0, 6'd9, 64'h1, 1, "R3 set already set");
    issue(2'b01, 1, 64'd0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R4 clear bit63 imm");
    issue(2'b01, 0, 64'd20, 6'd1, 64'h0000_0000_0000_00F0, 1, "R4 clear already clear");
    issue(2'b10, 0, 64'd40, 6'd0, 64'hA5A5_A5A5_A5A5_A5A5, 1, "R5 invert bit40");
    issue(2'b10, 1, 64'd7, 6'd0, 64'h1, 1, "R5 invert bit0 to zero");
    issue(2'b11, 0, 64'd63, 6'd2, 64'h8000_0000_0000_0000, 1, "R6 extract bit63");
    issue(2'b11, 1, 64'd3, 6'd4, 64'hFFFF_FFFF_FFFF_FFEF, 1, "R6 extract zero bit");
    issue(2'b11, 1, 64'd0, 6'd17, 64'h0000_0000_0002_0000, 1, "R6 extract one imm");
    issue(2'b00, 0, 64'hFFFF_FFFF_FFFF_FFC5, 6'd0, 64'd0, 1, "R2 reg upper bits ignored");
    issue(2'b10, 0, 64'd70, 6'd50, 64'd0, 1, "R2 reg index wraps to 6");
    issue(2'b10, 1, 64'd12, 6'd50, 64'd0, 1, "R2 imm wins over reg");
    issue(2'b00, 0, 64'd3, 6'd3, 64'h1234, 0, "R7 disabled set");
    issue(2'b11, 1, 64'd3, 6'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R7 disabled extract");
    issue(2'b01, 1, 64'd0, 6'd31, 64'hFFFF_FFFF_0000_0000, 1, "R8 back to back");
    idle(4);
    issue(2'b10, 0, 64'd62, 6'd0, 64'hFFFF_0000_FFFF_0000, 1, "R8 after idle");
    idle(3);
    for (int i = 0; i < 64; i++) begin
      issue(2'(i % 4), i[0], 64'(i) | 64'hDEAD_0000_0000_0000, 6'(63 - i),
            64'hC3C3_5A5A_0F0F_9669 ^ (64'd1 << i), (i % 9) != 0, "R2 R3 R4 R5 R6 sweep");
    end
    idle(4);
    check(q_res.size() == 0, "R8 all results seen", 64'(q_res.size()), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule